// File: doc/BRIEF.md
# Multiplexed Pixel Port with Per-Pixel Device Selection

This block takes in a wide pixel word once per load period and hands it out one pixel per pixel clock. In the two-pixel mode, each load carries two pixels. A load-strobe level is sampled in the pixel clock domain, and the first pixel of the word goes out before the second. In the single-pixel mode, the pixel clock itself acts as the load strobe: a fresh word is taken on every pixel clock and the strobe input has no effect. A blank flag, a sync flag and one two-bit select code per pixel travel with the colour data.

For each pixel, the select code is compared with a programmed two-bit field. On a mismatch the device counts as deselected: its colour and its sync-on-green output are forced dark, whatever the other inputs are. Sync can be merged onto the green path (a flag for the downstream converter) or sent out on a separate digital pin. Each route has its own enable. Every output passes through the same fixed-latency delay line, which stands in for the colour lookup and conversion stages, so all outputs stay time-aligned with each other.

The controller has four named states. `PH_IDLE` waits for a strobe edge. `PH_A` sends the first pixel of the held word. `PH_B` sends the second pixel. `PH_DIRECT` is the single-pixel mode.

The state transitions are:
- `PH_IDLE` to `PH_A` on a strobe edge.
- `PH_A` to `PH_B` always.
- `PH_B` to `PH_A` when another edge is waiting.
- `PH_B` to `PH_IDLE` when no edge is waiting.
- Any state to `PH_DIRECT` when two-pixel mode is cleared.
- `PH_DIRECT` to `PH_IDLE` when two-pixel mode is set again.

Top module: `pixmux_port`

## Requirements
- R1: While `rst_n` is low, the outputs are `blank_o`=1, `oe_o`=0, `sog_o`=0, `sync_o`=0 and `color_o`=0.
- R2: In two-pixel mode (`mode_2to1`=1), suppose `ld` is first sampled high at rising `clk` edge P. Pixel A (`pix_in[PIX_W-1:0]`) of the word present at P then appears on the outputs after edge P+LAT+2.
- R3: In two-pixel mode, pixel B (`pix_in[2*PIX_W-1:PIX_W]`) appears in the cycle right after pixel A. With `ld` toggling every clock, the pixels stream with no gap.
- R4: In single-pixel mode (`mode_2to1`=0), the word sampled at each rising edge P appears after edge P+LAT+2. Only pixel A is used, and `ld` has no effect.
- R5: Each pixel carries its own select code: `sel_in[1:0]` for pixel A and `sel_in[3:2]` for pixel B. `oe_o`=1 exactly when that code equals `sel_mode`. Otherwise `color_o`=0 and `sog_o`=0.
- R6: `blank_in`, captured with the word, applies to both of its pixels: `blank_o`=1 and `color_o`=0.
- R7: `sog_o` = the pixel's `sync_in` AND `sog_en` AND selected. It is 0 whenever `sog_en`=0.
- R8: `sync_o` = the pixel's `sync_in` AND `sync_out_en`, regardless of selection, with the same latency as the colour.
- R9: In two-pixel mode, when no new strobe edge follows pixel B, the next slot is idle: `blank_o`=1 and `oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld | input | 1 | Load strobe level, sampled in the `clk` domain |
| pix_in | input | 2*PIX_W | Pixel B in the upper half, pixel A in the lower half |
| sel_in | input | 4 | Select codes: B in [3:2], A in [1:0] |
| blank_in | input | 1 | Blank request for the word |
| sync_in | input | 1 | Sync request for the word (active high) |
| mode_2to1 | input | 1 | 1 = two pixels per load, 0 = one pixel per clock |
| sel_mode | input | 2 | Select code this device answers to |
| sog_en | input | 1 | Enable sync on the green path |
| sync_out_en | input | 1 | Enable the separate sync output |
| color_o | output | PIX_W | Colour word towards lookup and conversion |
| blank_o | output | 1 | Blank flag |
| sog_o | output | 1 | Sync-on-green flag |
| sync_o | output | 1 | Separate pipelined sync |
| oe_o | output | 1 | Device selected for this pixel |

## Verification
Every output for a pixel is due a fixed number of edges after its input word is sampled. Pixel A is due LAT+2 edges after the edge that samples it, which is the edge where `ld` is first seen high in two-pixel mode. Pixel B is due one edge after pixel A. In single-pixel mode the delay is also LAT+2 edges, counted from the edge that samples each word.

The bench drives inputs on falling edges and keeps a loop index aligned with rising edges. At index j it compares the outputs with the slot expected from the word driven at j-LAT-3. Each comparison happens on a falling edge, half a cycle after the output registers change. Idle slots after a burst are checked at the same offset.

// File: rtl/pixmux_pkg.sv
package pixmux_pkg;
    // Serializer phase; the encoding is internal to the block
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_A      = 2'd1,
        PH_B      = 2'd2,
        PH_DIRECT = 2'd3
    } phase_e;
endpackage

// File: rtl/pixmux_ldsync.sv
module pixmux_ldsync #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [DW-1:0] data_in,
    output logic          ld_edge,
    output logic [DW-1:0] data_out
);
    logic          s1, s2, s3;
    logic [DW-1:0] d1, d2;

    // Two-flop synchronizer on the strobe, plus one flop for edge detection.
    // The data runs alongside so that data_out is the word seen
    // when the strobe was first sampled high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
            d1 <= '0;
            d2 <= '0;
        end else begin
            s1 <= ld;
            s2 <= s1;
            s3 <= s2;
            d1 <= data_in;
            d2 <= d1;
        end
    end

    assign ld_edge  = s2 & ~s3;
    assign data_out = d2;
endmodule

// File: rtl/pixmux_fsm.sv
module pixmux_fsm
    import pixmux_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mode_2to1,
    input  logic   ld_edge,
    output phase_e phase,
    output logic   capture
);
    phase_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (!mode_2to1) begin
                    state_d = PH_DIRECT;
                    capture = 1'b1;
                end else if (ld_edge) begin
                    state_d = PH_A;
                    capture = 1'b1;
                end
            end
            PH_A: begin
                // an edge here would overwrite pixel B before it is sent, so none is taken
                if (!mode_2to1) begin
                    state_d = PH_DIRECT;
                    capture = 1'b1;
                end else begin
                    state_d = PH_B;
                end
            end
            PH_B: begin
                if (!mode_2to1) begin
                    state_d = PH_DIRECT;
                    capture = 1'b1;
                end else if (ld_edge) begin
                    state_d = PH_A;
                    capture = 1'b1;
                end else begin
                    state_d = PH_IDLE;
                end
            end
            PH_DIRECT: begin
                if (mode_2to1) state_d = PH_IDLE;
                else           capture = 1'b1;
            end
        endcase
    end

    assign phase = state_q;
endmodule

// File: rtl/pixmux_delay.sv
module pixmux_delay #(
    parameter int             W       = 8,
    parameter int             DEPTH   = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [DEPTH-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/pixmux_port.sv
module pixmux_port
    import pixmux_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int LAT   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld,
    input  logic [2*PIX_W-1:0] pix_in,
    input  logic [3:0]         sel_in,
    input  logic               blank_in,
    input  logic               sync_in,
    input  logic               mode_2to1,
    input  logic [1:0]         sel_mode,
    input  logic               sog_en,
    input  logic               sync_out_en,
    output logic [PIX_W-1:0]   color_o,
    output logic               blank_o,
    output logic               sog_o,
    output logic               sync_o,
    output logic               oe_o
);
    localparam int SEL_W  = 2;
    localparam int IN_W   = 2*PIX_W + 2*SEL_W + 2;
    localparam int SLOT_W = PIX_W + 4;
    // slot layout {oe, blank, sog, sync, color}
    localparam logic [SLOT_W-1:0] SLOT_IDLE = {1'b0, 1'b1, 1'b0, 1'b0, {PIX_W{1'b0}}};

    logic [IN_W-1:0]   in_word, smp_word, hold_q;
    logic              ld_edge, capture;
    phase_e            phase;

    assign in_word = {sync_in, blank_in, sel_in, pix_in};

    pixmux_ldsync #(.DW(IN_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ld),
        .data_in  (in_word),
        .ld_edge  (ld_edge),
        .data_out (smp_word)
    );

    pixmux_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_2to1 (mode_2to1),
        .ld_edge   (ld_edge),
        .phase     (phase),
        .capture   (capture)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_q <= '0;
        else if (capture) hold_q <= smp_word;
    end

    // Fields of the held word
    logic [PIX_W-1:0] h_pix_a, h_pix_b;
    logic [SEL_W-1:0] h_sel_a, h_sel_b;
    logic             h_blank, h_sync;

    assign h_pix_a = hold_q[PIX_W-1:0];
    assign h_pix_b = hold_q[2*PIX_W-1:PIX_W];
    assign h_sel_a = hold_q[2*PIX_W +: SEL_W];
    assign h_sel_b = hold_q[2*PIX_W+SEL_W +: SEL_W];
    assign h_blank = hold_q[IN_W-2];
    assign h_sync  = hold_q[IN_W-1];

    // Serializer: pick the pixel that belongs to the current phase
    logic             cur_valid;
    logic [PIX_W-1:0] cur_pix;
    logic [SEL_W-1:0] cur_sel;

    always_comb begin
        cur_valid = 1'b1;
        cur_pix   = h_pix_a;
        cur_sel   = h_sel_a;
        unique case (phase)
            PH_A, PH_DIRECT: begin
                cur_pix = h_pix_a;
                cur_sel = h_sel_a;
            end
            PH_B: begin
                cur_pix = h_pix_b;
                cur_sel = h_sel_b;
            end
            PH_IDLE: cur_valid = 1'b0;
        endcase
    end

    // Output formatting for the slot
    logic              f_oe, f_blank, f_sog, f_sync;
    logic [PIX_W-1:0]  f_color;
    logic [SLOT_W-1:0] slot_d, slot_q;

    always_comb begin
        f_oe    = cur_valid & (cur_sel == sel_mode);
        f_blank = ~cur_valid | h_blank;
        f_color = (f_oe & ~h_blank) ? cur_pix : '0;
        f_sog   = f_oe & sog_en & h_sync;
        f_sync  = cur_valid & sync_out_en & h_sync;
        slot_d  = {f_oe, f_blank, f_sog, f_sync, f_color};
    end

    pixmux_delay #(.W(SLOT_W), .DEPTH(LAT), .RST_VAL(SLOT_IDLE)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (slot_d),
        .q     (slot_q)
    );

    assign color_o = slot_q[PIX_W-1:0];
    assign sync_o  = slot_q[PIX_W];
    assign sog_o   = slot_q[PIX_W+1];
    assign blank_o = slot_q[PIX_W+2];
    assign oe_o    = slot_q[PIX_W+3];
endmodule

// File: rtl/pixmux_port_chk.sv
module pixmux_port_chk
    import pixmux_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input phase_e           phase,
    input logic             mode_2to1,
    input logic [PIX_W-1:0] color_o,
    input logic             blank_o,
    input logic             sog_o,
    input logic             sync_o,
    input logic             oe_o
);
    // R1: outputs idle while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r1: assert (blank_o && !oe_o && !sog_o && !sync_o && color_o == '0)
                else $error("reset outputs not idle");
        end
    end

    // R3: pixel B follows pixel A
    p_a_then_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_A && mode_2to1) |=> (phase == PH_B));

    // R4: single-pixel mode settles in the direct phase
    p_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_2to1 |=> (phase == PH_DIRECT));

    // R5: deselected pixel is dark
    p_desel_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> (color_o == '0 && !sog_o));

    // R6: blanked pixel is dark
    p_blank_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o |-> (color_o == '0));

    // R7: sync on green only on a selected pixel
    p_sog_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sog_o |-> oe_o);
endmodule

bind pixmux_port pixmux_port_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .mode_2to1 (mode_2to1),
    .color_o   (color_o),
    .blank_o   (blank_o),
    .sog_o     (sog_o),
    .sync_o    (sync_o),
    .oe_o      (oe_o)
);

// File: tb/pixmux_port_tb.sv
module pixmux_port_tb;
    localparam int PIX_W = 8;
    localparam int LAT   = 4;
    localparam int NW    = 12;
    localparam logic [1:0] MYSEL = 2'b10;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               ld;
    logic [2*PIX_W-1:0] pix_in;
    logic [3:0]         sel_in;
    logic               blank_in, sync_in;
    logic               mode_2to1;
    logic [1:0]         sel_mode;
    logic               sog_en, sync_out_en;
    logic [PIX_W-1:0]   color_o;
    logic               blank_o, sog_o, sync_o, oe_o;

    int n_checks = 0;
    int n_errors = 0;

    logic [PIX_W-1:0] wa [NW];
    logic [PIX_W-1:0] wb [NW];
    logic [1:0]       sa [NW];
    logic [1:0]       sb [NW];
    logic             bk [NW];
    logic             sy [NW];

    always #5 clk = ~clk;

    pixmux_port #(.PIX_W(PIX_W), .LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld(ld), .pix_in(pix_in), .sel_in(sel_in),
        .blank_in(blank_in), .sync_in(sync_in), .mode_2to1(mode_2to1),
        .sel_mode(sel_mode), .sog_en(sog_en), .sync_out_en(sync_out_en),
        .color_o(color_o), .blank_o(blank_o), .sog_o(sog_o), .sync_o(sync_o), .oe_o(oe_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare one output slot with the value the requirements give
    task automatic check_slot(input string tag, input bit v, input logic [PIX_W-1:0] pix,
                              input logic [1:0] sel, input bit b, input bit s);
        bit               e_oe;
        logic [PIX_W-1:0] e_col;
        e_oe  = v && (sel == sel_mode);
        e_col = (e_oe && !b) ? pix : '0;
        chk({tag, " colour"}, 32'(color_o), 32'(e_col));
        chk("R5 oe", 32'(oe_o), 32'(e_oe));
        chk("R6 blank", 32'(blank_o), 32'(!v || b));
        chk("R7 sog", 32'(sog_o), 32'(e_oe && sog_en && s));
        chk("R8 sync", 32'(sync_o), 32'(v && sync_out_en && s));
    endtask

    task automatic drive_word(input int w);
        pix_in   = {wb[w], wa[w]};
        sel_in   = {sb[w], sa[w]};
        blank_in = bk[w];
        sync_in  = sy[w];
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        ld = 1'b1; pix_in = '1; sel_in = {MYSEL, MYSEL}; blank_in = 1'b0; sync_in = 1'b1;
        mode_2to1 = 1'b1; sel_mode = MYSEL; sog_en = 1'b1; sync_out_en = 1'b1;
        repeat (3) @(negedge clk);
        // R1: idle outputs during reset
        chk("R1 blank", 32'(blank_o), 32'd1);
        chk("R1 oe", 32'(oe_o), 32'd0);
        chk("R1 sync", 32'(sync_o), 32'd0);
        chk("R1 sog", 32'(sog_o), 32'd0);
        chk("R1 colour", 32'(color_o), 32'd0);
        ld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (LAT + 4) @(negedge clk);
    endtask

    // Two pixels per load; R2 (A latency), R3 (B order), R9 (idle after burst)
    task automatic t_two_to_one(input bit sog, input bit so);
        mode_2to1 = 1'b1; sog_en = sog; sync_out_en = so; ld = 1'b0;
        repeat (LAT + 6) @(negedge clk);
        for (int j = 0; j < 2*NW + LAT + 6; j++) begin
            int idx;
            idx = j - LAT - 3;
            if (idx >= 0) begin
                if (idx < 2*NW) begin
                    if (idx % 2 == 0) check_slot("R2", 1'b1, wa[idx/2], sa[idx/2], bk[idx/2], sy[idx/2]);
                    else              check_slot("R3", 1'b1, wb[idx/2], sb[idx/2], bk[idx/2], sy[idx/2]);
                end else begin
                    check_slot("R9", 1'b0, '0, 2'b00, 1'b0, 1'b0);
                end
            end
            if (j < 2*NW) begin
                if (j % 2 == 0) begin
                    ld = 1'b1;
                    drive_word(j/2);
                end else begin
                    ld = 1'b0;
                end
            end else begin
                ld = 1'b0;
                pix_in = 16'(j * 16'h3c5);
            end
            @(negedge clk);
        end
    endtask

    // One pixel per clock, ld toggling and ignored; R4
    task automatic t_direct(input bit sog, input bit so);
        mode_2to1 = 1'b0; sog_en = sog; sync_out_en = so;
        repeat (LAT + 6) @(negedge clk);
        for (int j = 0; j < NW + LAT + 3; j++) begin
            int idx;
            idx = j - LAT - 3;
            if (idx >= 0 && idx < NW) check_slot("R4", 1'b1, wa[idx], sa[idx], bk[idx], sy[idx]);
            ld = j[0];
            if (j < NW) drive_word(j);
            @(negedge clk);
        end
        ld = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            wa[i] = PIX_W'(8'h11 + i * 8'h17);
            wb[i] = PIX_W'(8'hc3 ^ (i * 8'h0d));
            sa[i] = 2'(i);
            sb[i] = 2'(i + 2);
            bk[i] = (i % 5 == 3);
            sy[i] = (i % 3 == 1);
        end
        rst_n = 1'b1;
        ld = 1'b0; pix_in = '0; sel_in = '0; blank_in = 1'b0; sync_in = 1'b0;
        mode_2to1 = 1'b1; sel_mode = MYSEL; sog_en = 1'b0; sync_out_en = 1'b0;
        #2 rst_n = 1'b0;
        t_reset();
        t_two_to_one(1'b1, 1'b0);
        t_two_to_one(1'b0, 1'b1);
        t_direct(1'b1, 1'b1);
        t_direct(1'b0, 1'b0);
        t_two_to_one(1'b1, 1'b1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule